// File: doc/BRIEF.md
# Programmable Chip-Select Unit

This block turns the address of one bus access into a set of active-low chip selects and the access attributes that go with them. One select covers the top of memory, one covers the bottom, four share a movable midrange block, and six peripheral selects share a small movable block. That block can be placed in the 1 MB memory space or in the 64 KB I/O space. For each decoded access the block also reports how many wait states to insert, whether the external ready line must be honoured, and whether the target is 8 or 16 bits wide.

Software-visible setup goes through a plain register-write port. Each write loads one 32-bit word into one of five region registers. Accesses arrive on a valid/ready request channel and leave on a valid/ready result channel through one register stage. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result stage is empty or its result is being taken in the same cycle. A result stays valid with every field unchanged until the edge where `rsp_ready` is high. The block never drops a result and never drops a request. A request is decoded against the register contents seen on its acceptance edge. A configuration write on that same edge affects only later requests.

Top module: `csel_unit`

## Requirements
- R1: After reset there is no result pending, `req_ready` is high, the lower, midrange and peripheral regions are disabled, and the upper region is enabled. Its lower boundary is F0000h, it has 3 wait states, it requires external ready and it is 8 bits wide.
- R2: A request accepted on edge N gives `rsp_valid` high after edge N. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every result field holds its value.
- R3: A memory access with address greater than or equal to the upper boundary asserts `hi_sel_n`, and the region always runs through FFFFFh.
- R4: A memory access with address less than or equal to the lower region's end address asserts `lo_sel_n`.
- R5: The midrange block has size 8 KB << size code, with codes above 6 treated as 6. It matches when the address and the base agree above the block size, so base bits below the size are ignored. Bit i of `mid_sel_n` covers the i-th quarter of the block.
- R6: With the midrange mode bit set, `mid_sel_n[0]` asserts over the whole midrange block and bits 3..1 stay high.
- R7: The peripheral block is 2 KB aligned and holds eight 256-byte slots. Slot = address bits 10..8. Slots 0 to 3 drive `per_sel_n[3:0]`, slot 5 drives `per_sel_n[4]`, and slot 6 drives `per_sel_n[5]`. Slots 4 and 7 drive no select.
- R8: With the peripheral mode bit set, the peripheral block matches only I/O accesses, using address bits 15..0. With it clear, the block matches only memory accesses. An I/O access never asserts `hi_sel_n`, `lo_sel_n` or `mid_sel_n`.
- R9: The priority order is upper, then lower, then peripheral, then midrange. At most one select is low in any result.
- R10: Wait states are set by the 3-bit wait code. The upper, lower and midrange regions and peripheral slots 5 and 6 use code bits 1..0 as 0 to 3. Peripheral slots 0 to 3 use codes 0 to 3 as-is and map codes 4, 5, 6 and 7 to 5, 7, 9 and 15.
- R11: `bus_wide` is the region's own width bit for the upper, lower and midrange regions. A peripheral select in memory space takes the midrange width bit. A peripheral select in I/O space takes the I/O width bit.
- R12: A configuration word has the base or end address in bits 31..12, the size code in bits 10..8, the mode in bit 6, enable in bit 5, width in bit 4, ready-required in bit 3 and the wait code in bits 2..0. Index 0 is upper, 1 is lower, 2 is midrange and 3 is peripheral. Index 4 sets the I/O width from bit 4. Writes to indexes 5 to 7 change nothing.
- R13: An access that matches no region gives all selects high, zero wait states, ready-required low and `bus_wide` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index for the write |
| cfg_data | input | 32 | Configuration word |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 20 | Access address (I/O uses bits 15..0) |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| hi_sel_n | output | 1 | Upper-memory select, active low |
| lo_sel_n | output | 1 | Lower-memory select, active low |
| mid_sel_n | output | 4 | Midrange selects, active low |
| per_sel_n | output | 6 | Peripheral selects, active low (slots 0-3, 5, 6) |
| wait_states | output | 4 | Wait states for the access |
| need_ext_rdy | output | 1 | External ready must be honoured |
| bus_wide | output | 1 | 1 = 16-bit target, 0 = 8-bit |

## Verification
The bench builds the block with its default parameters: an 8 KB minimum midrange granule, 256-byte peripheral slots and a 16-bit I/O space. With these values a 64 KB midrange block splits into 16 KB quarters at known addresses. The peripheral slots sit at 256-byte steps, where slots 4 and 7 fall through, and an I/O base can share its number with a memory address covered by the lower region. Together these bring every priority pairing, both peripheral wait-code maps and the width routing into reach with fixed, hand-computed expectations.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int CS_AW = 20;
  localparam int CS_DW = 32;

  typedef enum logic [2:0] {
    RG_UPPER = 3'd0,
    RG_LOWER = 3'd1,
    RG_MID   = 3'd2,
    RG_PER   = 3'd3,
    RG_IOW   = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic [CS_AW-1:0] base;
    logic [2:0]       size;
    logic             mode;
    logic             en;
    logic             wide;
    logic             rdy;
    logic [2:0]       wcode;
  } region_t;

  typedef struct packed {
    logic       hi_n;
    logic       lo_n;
    logic [3:0] mid_n;
    logic [5:0] per_n;
    logic [3:0] waits;
    logic       rdy;
    logic       wide;
  } result_t;

  localparam result_t RES_IDLE = '{hi_n: 1'b1, lo_n: 1'b1, mid_n: 4'hF,
                                   per_n: 6'h3F, waits: 4'd0, rdy: 1'b0,
                                   wide: 1'b0};

  function automatic region_t unpack_cfg(input logic [CS_DW-1:0] d);
    region_t r;
    r.base  = d[31:12];
    r.size  = d[10:8];
    r.mode  = d[6];
    r.en    = d[5];
    r.wide  = d[4];
    r.rdy   = d[3];
    r.wcode = d[2:0];
    return r;
  endfunction

  function automatic logic [3:0] wait_long(input logic [2:0] c);
    case (c)
      3'd4:    return 4'd5;
      3'd5:    return 4'd7;
      3'd6:    return 4'd9;
      3'd7:    return 4'd15;
      default: return {1'b0, c};
    endcase
  endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       idx,
  input  logic [CS_DW-1:0] data,
  output region_t          up_q,
  output region_t          lo_q,
  output region_t          mid_q,
  output region_t          per_q,
  output logic             io_wide_q
);
  localparam region_t UP_RST = '{base: 20'hF0000, size: 3'd0, mode: 1'b0,
                                 en: 1'b1, wide: 1'b0, rdy: 1'b1, wcode: 3'd3};
  localparam region_t OFF_RST = '0;

  logic unused_bits;
  assign unused_bits = ^{data[11], data[7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q      <= UP_RST;
      lo_q      <= OFF_RST;
      mid_q     <= OFF_RST;
      per_q     <= OFF_RST;
      io_wide_q <= 1'b0;
    end else if (we) begin
      case (reg_idx_e'(idx))
        RG_UPPER: up_q      <= unpack_cfg(data);
        RG_LOWER: lo_q      <= unpack_cfg(data);
        RG_MID:   mid_q     <= unpack_cfg(data);
        RG_PER:   per_q     <= unpack_cfg(data);
        RG_IOW:   io_wide_q <= data[4];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
#(
  parameter int MID_MIN_LG = 13,
  parameter int PER_LG     = 8,
  parameter int IO_W       = 16
) (
  input  logic [CS_AW-1:0] addr,
  input  logic             io,
  input  region_t          up,
  input  region_t          lo,
  input  region_t          mid,
  input  region_t          per,
  input  logic             io_wide,
  output result_t          res
);
  localparam int PER_BLK_LG   = PER_LG + 3;
  localparam int MID_MAX_CODE = CS_AW - 1 - MID_MIN_LG;
  localparam int N_MID        = 4;
  localparam int N_PER        = 6;

  logic             hit_hi, hit_lo, hit_mid, hit_per, per_blk;
  logic             take_hi, take_lo, take_mid, take_per;
  logic [2:0]       slot;
  logic [2:0]       msz;
  int               mlg;
  logic [CS_AW-1:0] mmask, msh;
  logic [1:0]       mq;
  logic [N_MID-1:0] mid_v;
  logic [N_PER-1:0] per_v;

  logic unused_fields;
  assign unused_fields = ^{up.size, up.mode, lo.size, lo.mode, per.size, per.wide};

  // midrange geometry
  always_comb begin
    msz   = (mid.size > 3'(MID_MAX_CODE)) ? 3'(MID_MAX_CODE) : mid.size;
    mlg   = MID_MIN_LG + int'(msz);
    mmask = {CS_AW{1'b1}} << mlg;
    msh   = addr >> (mlg - 2);
    mq    = msh[1:0];
  end

  assign slot = addr[PER_LG+2:PER_LG];

  always_comb begin
    if (per.mode)
      per_blk = io && (addr[IO_W-1:PER_BLK_LG] == per.base[IO_W-1:PER_BLK_LG]);
    else
      per_blk = !io && (addr[CS_AW-1:PER_BLK_LG] == per.base[CS_AW-1:PER_BLK_LG]);
  end

  assign hit_hi  = !io && up.en && (addr >= up.base);
  assign hit_lo  = !io && lo.en && (addr <= lo.base);
  assign hit_mid = !io && mid.en && (((addr ^ mid.base) & mmask) == '0);
  assign hit_per = per.en && per_blk && (slot != 3'd4) && (slot != 3'd7);

  assign take_hi  = hit_hi;
  assign take_lo  = hit_lo && !hit_hi;
  assign take_per = hit_per && !hit_hi && !hit_lo;
  assign take_mid = hit_mid && !hit_hi && !hit_lo && !hit_per;

  for (genvar g = 0; g < N_MID; g++) begin : g_mid
    assign mid_v[g] = take_mid && (mid.mode ? (g == 0) : (mq == 2'(g)));
  end

  for (genvar g = 0; g < N_PER; g++) begin : g_per
    localparam int SLOT = (g < 4) ? g : g + 1;
    assign per_v[g] = take_per && (slot == 3'(SLOT));
  end

  always_comb begin
    res       = RES_IDLE;
    res.hi_n  = !take_hi;
    res.lo_n  = !take_lo;
    res.mid_n = ~mid_v;
    res.per_n = ~per_v;
    if (take_hi) begin
      res.waits = {2'b00, up.wcode[1:0]};
      res.rdy   = up.rdy;
      res.wide  = up.wide;
    end else if (take_lo) begin
      res.waits = {2'b00, lo.wcode[1:0]};
      res.rdy   = lo.rdy;
      res.wide  = lo.wide;
    end else if (take_per) begin
      res.waits = slot[2] ? {2'b00, per.wcode[1:0]} : wait_long(per.wcode);
      res.rdy   = per.rdy;
      res.wide  = per.mode ? io_wide : mid.wide;
    end else if (take_mid) begin
      res.waits = {2'b00, mid.wcode[1:0]};
      res.rdy   = mid.rdy;
      res.wide  = mid.wide;
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int MID_MIN_LG = 13,
  parameter int PER_LG     = 8,
  parameter int IO_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_idx,
  input  logic [31:0] cfg_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [19:0] req_addr,
  input  logic        req_io,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        hi_sel_n,
  output logic        lo_sel_n,
  output logic [3:0]  mid_sel_n,
  output logic [5:0]  per_sel_n,
  output logic [3:0]  wait_states,
  output logic        need_ext_rdy,
  output logic        bus_wide
);
  region_t up_r, lo_r, mid_r, per_r;
  logic    io_wide_r;
  result_t res_d, res_q;
  logic    accept;

  csel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .data(cfg_data),
    .up_q(up_r), .lo_q(lo_r), .mid_q(mid_r), .per_q(per_r), .io_wide_q(io_wide_r)
  );

  csel_decode #(.MID_MIN_LG(MID_MIN_LG), .PER_LG(PER_LG), .IO_W(IO_W)) u_dec (
    .addr(req_addr), .io(req_io), .up(up_r), .lo(lo_r), .mid(mid_r),
    .per(per_r), .io_wide(io_wide_r), .res(res_d)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      res_q     <= RES_IDLE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      res_q     <= res_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign hi_sel_n     = res_q.hi_n;
  assign lo_sel_n     = res_q.lo_n;
  assign mid_sel_n    = res_q.mid_n;
  assign per_sel_n    = res_q.per_n;
  assign wait_states  = res_q.waits;
  assign need_ext_rdy = res_q.rdy;
  assign bus_wide     = res_q.wide;
endmodule

// File: rtl/csel_checks.sv
module csel_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_io,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       hi_sel_n,
  input logic       lo_sel_n,
  input logic [3:0] mid_sel_n,
  input logic [5:0] per_sel_n,
  input logic [3:0] wait_states,
  input logic       need_ext_rdy,
  input logic       bus_wide
);
  logic [11:0] sels_n;
  assign sels_n = {hi_sel_n, lo_sel_n, mid_sel_n, per_sel_n};

  assert_accept_gives_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(sels_n) && $stable(wait_states)
                                   && $stable(need_ext_rdy) && $stable(bus_wide)));

  assert_single_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(~sels_n));

  assert_io_no_memory_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_io) |=> (hi_sel_n && lo_sel_n && (&mid_sel_n)));

  assert_short_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(&per_sel_n[5:4])) |-> (wait_states <= 4'd3));

  assert_idle_attrs_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (&sels_n)) |-> (wait_states == 4'd0 && !need_ext_rdy && !bus_wide));
endmodule

bind csel_unit csel_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_io(req_io), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n), .mid_sel_n(mid_sel_n),
  .per_sel_n(per_sel_n), .wait_states(wait_states),
  .need_ext_rdy(need_ext_rdy), .bus_wide(bus_wide)
);

// File: tb/test_csel_unit.sv
`timescale 1ns/100ps
module test_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        hi_sel_n, lo_sel_n, bus_wide, need_ext_rdy;
  logic [3:0]  mid_sel_n, wait_states;
  logic [5:0]  per_sel_n;

  int total = 0;
  int fails = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  csel_unit i_csel_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
    .mid_sel_n(mid_sel_n), .per_sel_n(per_sel_n), .wait_states(wait_states),
    .need_ext_rdy(need_ext_rdy), .bus_wide(bus_wide)
  );

  function automatic logic [17:0] observed();
    return {hi_sel_n, lo_sel_n, mid_sel_n, per_sel_n, wait_states, need_ext_rdy, bus_wide};
  endfunction

  // kind: 0 none, 1 upper, 2 lower, 3 midrange, 4 peripheral
  function automatic logic [17:0] mk(int kind, int idx, int w, bit rdy, bit wide);
    logic hi = 1'b1, lo = 1'b1;
    logic [3:0] mid = 4'hF;
    logic [5:0] per = 6'h3F;
    if (kind == 1) hi = 1'b0;
    if (kind == 2) lo = 1'b0;
    if (kind == 3) mid[idx] = 1'b0;
    if (kind == 4) per[(idx < 4) ? idx : idx - 1] = 1'b0;
    if (kind == 0) return {hi, lo, mid, per, 4'd0, 1'b0, 1'b0};
    return {hi, lo, mid, per, 4'(w), rdy, wide};
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] idx, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic issue(string tag, logic [19:0] a, bit io, logic [17:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_io = io;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor: a result counts as delivered when valid and ready at a negedge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check("R2 unexpected result", observed(), 18'h0);
        else check(tag_q.pop_front(), observed(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", {16'h0, rsp_valid, req_ready}, {16'h0, 1'b0, 1'b1});

    // reset upper region
    issue("R1 reset upper F0000", 20'hF0000, 0, mk(1, 0, 3, 1, 0));
    issue("R3 top FFFFF", 20'hFFFFF, 0, mk(1, 0, 3, 1, 0));
    issue("R13 below upper", 20'hEFFFF, 0, mk(0, 0, 0, 0, 0));
    issue("R8 io never upper", 20'hF0000, 1, mk(0, 0, 0, 0, 0));

    // R12 layout: base in 31..12, en 0x20, wide 0x10, rdy 0x08, code 2..0
    cfg_write(3'd0, {20'hC0000, 12'h031});
    cfg_write(3'd1, {20'h0FFFF, 12'h02A});
    issue("R3 new boundary", 20'hC0000, 0, mk(1, 0, 1, 0, 1));
    issue("R4 lower end", 20'h0FFFF, 0, mk(2, 0, 2, 1, 0));
    issue("R4 above lower", 20'h10000, 0, mk(0, 0, 0, 0, 0));

    // midrange 64 KB at 80000h
    cfg_write(3'd2, {20'h80000, 12'h333});
    issue("R5 quarter 0", 20'h80000, 0, mk(3, 0, 3, 0, 1));
    issue("R5 quarter 1", 20'h84000, 0, mk(3, 1, 3, 0, 1));
    issue("R5 quarter 3", 20'h8C000, 0, mk(3, 3, 3, 0, 1));
    issue("R5 outside block", 20'h90000, 0, mk(0, 0, 0, 0, 0));
    cfg_write(3'd2, {20'h80000, 12'h373});
    issue("R6 whole block", 20'h8C000, 0, mk(3, 0, 3, 0, 1));

    // peripheral in memory at 20000h, code 6
    cfg_write(3'd3, {20'h20000, 12'h02E});
    issue("R7 slot 0", 20'h20000, 0, mk(4, 0, 9, 1, 1));
    issue("R10 slot 3 long wait", 20'h20300, 0, mk(4, 3, 9, 1, 1));
    issue("R7 slot 4 absent", 20'h20400, 0, mk(0, 0, 0, 0, 0));
    issue("R10 slot 5 short wait", 20'h20500, 0, mk(4, 5, 2, 1, 1));
    issue("R7 slot 6", 20'h20600, 0, mk(4, 6, 2, 1, 1));
    issue("R7 slot 7 absent", 20'h20700, 0, mk(0, 0, 0, 0, 0));
    issue("R8 memory block ignores io", 20'h20000, 1, mk(0, 0, 0, 0, 0));

    // priority: peripheral inside midrange, upper over lower
    cfg_write(3'd3, {20'h88000, 12'h02E});
    issue("R9 peripheral over midrange", 20'h88000, 0, mk(4, 0, 9, 1, 1));
    cfg_write(3'd1, {20'hC8000, 12'h02A});
    issue("R9 upper over lower", 20'hC4000, 0, mk(1, 0, 1, 0, 1));
    cfg_write(3'd1, {20'h0FFFF, 12'h02A});

    // peripheral in I/O at 3000h, code 7, I/O width 16
    cfg_write(3'd3, {20'h03000, 12'h06F});
    cfg_write(3'd4, {20'h00000, 12'h010});
    issue("R11 io slot 0 io width", 20'h03000, 1, mk(4, 0, 15, 1, 1));
    issue("R10 io slot 6", 20'h03600, 1, mk(4, 6, 3, 1, 1));
    issue("R8 memory same number", 20'h03000, 0, mk(2, 0, 2, 1, 0));
    issue("R8 io outside block", 20'h0FFFF, 1, mk(0, 0, 0, 0, 0));
    cfg_write(3'd4, {20'h00000, 12'h000});
    issue("R11 io width cleared", 20'h03000, 1, mk(4, 0, 15, 1, 0));

    // unused index leaves everything as it was
    cfg_write(3'd5, 32'hFFFF_FFFF);
    cfg_write(3'd7, 32'h0000_0000);
    issue("R12 index 5 ignored", 20'h03000, 1, mk(4, 0, 15, 1, 0));
    issue("R12 index 7 ignored", 20'hC0000, 0, mk(1, 0, 1, 0, 1));

    // back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    issue("R2 stalled result", 20'h84000, 0, mk(3, 0, 3, 0, 1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 stall state", {16'h0, rsp_valid, req_ready}, {16'h0, 1'b1, 1'b0});
      check("R2 stall fields", observed(), mk(3, 0, 3, 0, 1));
    end
    @(posedge clk); #1 rsp_ready = 1'b1;

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) check("R2 pending results", 18'(exp_q.size()), 18'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule